// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block holds the control lines of four IO bank channels and moves them between a frozen and a thawed condition in a fixed order. That order keeps glitches caused by pin-mux or buffer reconfiguration away from external devices. Channels 0, 1 and 2 are general-purpose banks, each with five control lines. Channel 3 is a memory-interface bank with nine control lines. The extra four lines on channel 3 carry delay-line reset, termination reset, register reset and termination calibration start.

A caller presents a one-cycle request with a direction bit (1 = freeze, 0 = thaw) and a channel number. The sequencer then changes the control lines step by step. Between steps it waits either a parameterised number of clock cycles, which stand in for nanosecond-scale minimums, or a number of rising edges on a separate oscillator strobe. When a sequence ends, a one-cycle completion pulse is raised and the channel's frozen flag is updated. A request for a channel that does not exist is refused with a one-cycle error pulse. An oscillator wait that stops seeing strobe edges is abandoned with the same error pulse.

Top module: `io_freeze_seq`

## Requirements
- R1: After reset, every general bank's lines read 5'b00000, the memory bank reads 9'h0E0, `frozen` is 4'hF, and `busy`, `done` and `err` are low. Control bit map: bit4 slew enable (active low), bit3 weak pull-up enable (active low), bit2 tristate (active low), bit1 bus-hold (active low), bit0 configuration-done (active high); memory bank only: bit5 delay-line reset, bit6 termination reset, bit7 register reset, bit8 calibration start.
- R2: Freezing a general bank clears bits 4,3,2 one cycle after acceptance. It clears bits 1,0 `GEN_WAIT_CYC` cycles later.
- R3: Thawing a general bank sets bits 1,0 first. It sets bits 3,2 `GEN_WAIT_CYC` cycles later, and sets bit4 after another `GEN_WAIT_CYC` cycles.
- R4: Freezing the memory bank clears bits 4,3,2. After `MEM_WAIT_CYC` cycles it clears bits 1,0 and sets bits 7,6. After another `MEM_WAIT_CYC` cycles it clears bit8 and sets bit5.
- R5: Thawing the memory bank runs six steps in this order:
  1. Clear bit5, then wait `MEM_WAIT_CYC` cycles.
  2. Set bit8, then wait `OSC_LONG` strobe edges.
  3. Set bits 1,0 and clear bit6, then wait `OSC_SHORT` strobe edges.
  4. Set bits 3,2, then wait `MEM_WAIT_CYC` cycles.
  5. Clear bit7, then wait `MEM_WAIT_CYC` cycles.
  6. Set bit4.

  The step that ends an oscillator wait happens in the cycle after the counted edge has been seen.
- R6: A request with a channel number above 3 raises `err` for one cycle. It leaves every control line, `frozen` and `busy` unchanged.
- R7: A request that arrives while `busy` is high is ignored.
- R8: When a sequence finishes, `done` is high for exactly one cycle. In that same cycle `frozen[ch]` takes the request's direction bit and `busy` falls. At all other times `frozen` does not change.
- R9: If an oscillator wait sees no strobe rising edge for `STALL_LIMIT` consecutive cycles, the sequence is abandoned. `err` pulses, `busy` falls, the lines keep their present values and `frozen` is unchanged.
- R10: Every general bank always obeys two ordering rules: bit4 high implies bits 3 and 2 are high, and either of bits 3 or 2 high implies bits 1 and 0 are high. On the memory bank, bits 5 and 8 are never high together.
- R11: A sequence changes only the lines of the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_freeze | input | 1 | Direction: 1 freeze, 0 thaw |
| req_chan | input | CHW | Channel number of the request |
| osc_tick | input | 1 | Oscillator strobe, synchronous to clk; rising edges are counted |
| gen_ctrl | output | 15 | Control lines of channels 0..2, channel g at bits [5g+4:5g] |
| mem_ctrl | output | 9 | Control lines of the memory bank (channel 3) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | One-cycle pulse on a refused request or an oscillator stall |
| frozen | output | 4 | Per-channel frozen flag |

## Verification
The assertions assume that `req_chan` and `req_freeze` are meaningful only while `req_valid` is high. They also assume that `osc_tick` is a clean strobe, already synchronous to `clk`, and much slower than it. The bench changes all inputs on the falling clock edge. It drives the oscillator strobe high for one cycle in every four. A stall is produced only by switching the strobe off entirely for longer than the stall limit. Requests made while a sequence runs are placed in the middle of a long oscillator wait, so being ignored shows as a final line state that would otherwise differ.

// File: rtl/fz_pkg.sv
package fz_pkg;

    localparam int GEN_W  = 5;
    localparam int MEM_W  = 9;
    localparam int NCH    = 4;
    localparam int NGEN   = 3;
    localparam int MEM_CH = 3;

    // Control bit masks; positions are decoded by the pad ring
    localparam logic [MEM_W-1:0] M_CDONE = 9'h001;
    localparam logic [MEM_W-1:0] M_HOLD  = 9'h002;
    localparam logic [MEM_W-1:0] M_TRI   = 9'h004;
    localparam logic [MEM_W-1:0] M_PULL  = 9'h008;
    localparam logic [MEM_W-1:0] M_SLEW  = 9'h010;
    localparam logic [MEM_W-1:0] M_DLL   = 9'h020;
    localparam logic [MEM_W-1:0] M_TERM  = 9'h040;
    localparam logic [MEM_W-1:0] M_REG   = 9'h080;
    localparam logic [MEM_W-1:0] M_CAL   = 9'h100;

    localparam logic [MEM_W-1:0] MEM_FROZEN = M_DLL | M_TERM | M_REG;

    typedef enum logic [1:0] {
        W_CYC_GEN,
        W_CYC_MEM,
        W_OSC_LONG,
        W_OSC_SHORT
    } wait_kind_e;

    typedef struct packed {
        logic [MEM_W-1:0] clr;
        logic [MEM_W-1:0] set;
        wait_kind_e       wk;
        logic             last;
    } step_t;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } fsm_e;

endpackage

// File: rtl/fz_step_table.sv
module fz_step_table
    import fz_pkg::*;
(
    input  logic        op_freeze,
    input  logic        mem_bank,
    input  logic [2:0]  idx,
    output step_t       stp
);

    always_comb begin
        stp      = '0;
        stp.wk   = W_CYC_GEN;
        unique case ({mem_bank, op_freeze})
            2'b01: begin
                case (idx)
                    3'd0: begin
                        stp.clr = M_SLEW | M_PULL | M_TRI;
                        stp.wk  = W_CYC_GEN;
                    end
                    default: begin
                        stp.clr  = M_HOLD | M_CDONE;
                        stp.last = 1'b1;
                    end
                endcase
            end
            2'b00: begin
                case (idx)
                    3'd0: begin
                        stp.set = M_HOLD | M_CDONE;
                        stp.wk  = W_CYC_GEN;
                    end
                    3'd1: begin
                        stp.set = M_PULL | M_TRI;
                        stp.wk  = W_CYC_GEN;
                    end
                    default: begin
                        stp.set  = M_SLEW;
                        stp.last = 1'b1;
                    end
                endcase
            end
            2'b11: begin
                case (idx)
                    3'd0: begin
                        stp.clr = M_SLEW | M_PULL | M_TRI;
                        stp.wk  = W_CYC_MEM;
                    end
                    3'd1: begin
                        stp.clr = M_HOLD | M_CDONE;
                        stp.set = M_REG | M_TERM;
                        stp.wk  = W_CYC_MEM;
                    end
                    default: begin
                        stp.clr  = M_CAL;
                        stp.set  = M_DLL;
                        stp.last = 1'b1;
                    end
                endcase
            end
            default: begin
                case (idx)
                    3'd0: begin
                        stp.clr = M_DLL;
                        stp.wk  = W_CYC_MEM;
                    end
                    3'd1: begin
                        stp.set = M_CAL;
                        stp.wk  = W_OSC_LONG;
                    end
                    3'd2: begin
                        stp.set = M_HOLD | M_CDONE;
                        stp.clr = M_TERM;
                        stp.wk  = W_OSC_SHORT;
                    end
                    3'd3: begin
                        stp.set = M_PULL | M_TRI;
                        stp.wk  = W_CYC_MEM;
                    end
                    3'd4: begin
                        stp.clr = M_REG;
                        stp.wk  = W_CYC_MEM;
                    end
                    default: begin
                        stp.set  = M_SLEW;
                        stp.last = 1'b1;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/fz_wait_timer.sv
module fz_wait_timer #(
    parameter int CW          = 10,
    parameter int STALL_LIMIT = 1000,
    localparam int SW         = $clog2(STALL_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_osc,
    input  logic [CW-1:0] load_len,
    input  logic          osc_tick,
    output logic          fin,
    output logic          stall_hit
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          osc;
        logic [SW-1:0] stall;
        logic          prev;
    } tmr_t;

    tmr_t t_q, t_d;
    logic rise;

    assign rise      = osc_tick & ~t_q.prev;
    assign fin       = (t_q.cnt == '0);
    assign stall_hit = t_q.osc && (t_q.cnt != '0) && (t_q.stall == SW'(STALL_LIMIT));

    always_comb begin
        t_d      = t_q;
        t_d.prev = osc_tick;
        if (load) begin
            t_d.cnt   = load_len;
            t_d.osc   = load_osc;
            t_d.stall = '0;
        end else if (t_q.cnt != '0) begin
            if (!t_q.osc) begin
                t_d.cnt = t_q.cnt - 1'b1;
            end else if (rise) begin
                t_d.cnt   = t_q.cnt - 1'b1;
                t_d.stall = '0;
            end else if (t_q.stall != SW'(STALL_LIMIT)) begin
                t_d.stall = t_q.stall + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/io_freeze_seq.sv
module io_freeze_seq
    import fz_pkg::*;
#(
    parameter int GEN_WAIT_CYC = 1,
    parameter int MEM_WAIT_CYC = 2,
    parameter int OSC_LONG     = 1000,
    parameter int OSC_SHORT    = 33,
    parameter int STALL_LIMIT  = 1000,
    parameter int CHW          = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_freeze,
    input  logic [CHW-1:0]         req_chan,
    input  logic                   osc_tick,
    output logic [NGEN*GEN_W-1:0]  gen_ctrl,
    output logic [MEM_W-1:0]       mem_ctrl,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic [NCH-1:0]         frozen
);

    localparam int CH_IDX_W = $clog2(NCH);
    localparam int MAX_A    = (GEN_WAIT_CYC > MEM_WAIT_CYC) ? GEN_WAIT_CYC : MEM_WAIT_CYC;
    localparam int MAX_B    = (OSC_LONG > OSC_SHORT) ? OSC_LONG : OSC_SHORT;
    localparam int MAX_W    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW       = $clog2(MAX_W + 1);

    typedef struct packed {
        fsm_e                         st;
        logic                         op;
        logic [CH_IDX_W-1:0]          ch;
        logic [2:0]                   idx;
        logic                         done;
        logic                         err;
        logic [NCH-1:0]               frozen;
        logic [NGEN-1:0][GEN_W-1:0]   gen;
        logic [MEM_W-1:0]             mem;
    } seq_t;

    seq_t r_q, r_d;

    step_t          stp;
    logic           t_load, t_osc, t_fin, t_stall;
    logic [CW-1:0]  t_len;

    function automatic logic [CW-1:0] wait_len(input wait_kind_e k);
        case (k)
            W_CYC_GEN:  return CW'(GEN_WAIT_CYC - 1);
            W_CYC_MEM:  return CW'(MEM_WAIT_CYC - 1);
            W_OSC_LONG: return CW'(OSC_LONG);
            default:    return CW'(OSC_SHORT);
        endcase
    endfunction

    fz_step_table u_table (
        .op_freeze (r_q.op),
        .mem_bank  (r_q.ch == CH_IDX_W'(MEM_CH)),
        .idx       (r_q.idx),
        .stp       (stp)
    );

    fz_wait_timer #(
        .CW          (CW),
        .STALL_LIMIT (STALL_LIMIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (t_load),
        .load_osc  (t_osc),
        .load_len  (t_len),
        .osc_tick  (osc_tick),
        .fin       (t_fin),
        .stall_hit (t_stall)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        t_load   = 1'b0;
        t_osc    = 1'b0;
        t_len    = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_chan > CHW'(NCH - 1)) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.st  = ST_RUN;
                        r_d.op  = req_freeze;
                        r_d.ch  = req_chan[CH_IDX_W-1:0];
                        r_d.idx = '0;
                        t_load  = 1'b1;
                    end
                end
            end
            default: begin
                if (t_fin) begin
                    for (int g = 0; g < NGEN; g++) begin
                        if (r_q.ch == CH_IDX_W'(g)) begin
                            r_d.gen[g] = (r_q.gen[g] & ~stp.clr[GEN_W-1:0]) | stp.set[GEN_W-1:0];
                        end
                    end
                    if (r_q.ch == CH_IDX_W'(MEM_CH)) begin
                        r_d.mem = (r_q.mem & ~stp.clr) | stp.set;
                    end
                    if (stp.last) begin
                        r_d.st             = ST_IDLE;
                        r_d.done           = 1'b1;
                        r_d.frozen[r_q.ch] = r_q.op;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        t_load  = 1'b1;
                        t_osc   = (stp.wk == W_OSC_LONG) || (stp.wk == W_OSC_SHORT);
                        t_len   = wait_len(stp.wk);
                    end
                end else if (t_stall) begin
                    r_d.st  = ST_IDLE;
                    r_d.err = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.frozen <= '1;
            r_q.mem    <= MEM_FROZEN;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NGEN; g++) begin : g_gen_out
        assign gen_ctrl[g*GEN_W +: GEN_W] = r_q.gen[g];
    end

    assign mem_ctrl = r_q.mem;
    assign busy     = (r_q.st == ST_RUN);
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign frozen   = r_q.frozen;

endmodule

// File: rtl/fz_seq_chk.sv
module fz_seq_chk #(
    parameter int NGEN  = 3,
    parameter int GEN_W = 5,
    parameter int MEM_W = 9,
    parameter int NCH   = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy,
    input logic                   done,
    input logic                   err,
    input logic [NCH-1:0]         frozen,
    input logic [NGEN*GEN_W-1:0]  gen_ctrl,
    input logic [MEM_W-1:0]       mem_ctrl
);

    // R6
    lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(gen_ctrl) && $stable(mem_ctrl)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(frozen));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err));

    // R10
    mem_dll_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ctrl[5] |-> !mem_ctrl[8]);

    for (genvar g = 0; g < NGEN; g++) begin : g_order
        // R10
        slew_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gen_ctrl[g*GEN_W + 4] |-> (gen_ctrl[g*GEN_W + 3] && gen_ctrl[g*GEN_W + 2]));
        // R10
        hold_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_ctrl[g*GEN_W + 3] || gen_ctrl[g*GEN_W + 2])
                |-> (gen_ctrl[g*GEN_W + 1] && gen_ctrl[g*GEN_W + 0]));
    end

endmodule

bind io_freeze_seq fz_seq_chk #(
    .NGEN  (fz_pkg::NGEN),
    .GEN_W (fz_pkg::GEN_W),
    .MEM_W (fz_pkg::MEM_W),
    .NCH   (fz_pkg::NCH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .frozen   (frozen),
    .gen_ctrl (gen_ctrl),
    .mem_ctrl (mem_ctrl)
);

// File: tb/tb_io_freeze_seq.sv
`timescale 1ns/1ps
module tb_io_freeze_seq;

    localparam int GWC = 1;
    localparam int MWC = 2;
    localparam int OL  = 1000;
    localparam int OS  = 33;
    localparam int SL  = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_freeze = 1'b0;
    logic [2:0]  req_chan = '0;
    logic        osc_tick = 1'b0;
    logic [14:0] gen_ctrl;
    logic [8:0]  mem_ctrl;
    logic        busy, done, err;
    logic [3:0]  frozen;

    always #10 clk = ~clk;

    io_freeze_seq #(
        .GEN_WAIT_CYC (GWC), .MEM_WAIT_CYC (MWC), .OSC_LONG (OL),
        .OSC_SHORT (OS), .STALL_LIMIT (SL), .CHW (3)
    ) dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_freeze (req_freeze), .req_chan (req_chan), .osc_tick (osc_tick),
        .gen_ctrl (gen_ctrl), .mem_ctrl (mem_ctrl), .busy (busy),
        .done (done), .err (err), .frozen (frozen)
    );

    // ---------------- reference model ----------------
    typedef struct {
        logic [8:0] clr;
        logic [8:0] set;
        bit         osc;
        int         len;
    } mstep_t;

    mstep_t     q[$];
    logic [4:0] m_gen [3];
    logic [8:0] m_mem;
    logic [3:0] m_frozen;
    bit         m_busy, m_done, m_err, m_osc, m_prev, m_op;
    int         m_cnt, m_stall, m_ch;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    started = 0;
    bit    osc_en = 0;
    int    osc_div = 0;
    string tag = "R1";

    function automatic void push(logic [8:0] c, logic [8:0] s, bit o, int n);
        mstep_t e;
        e.clr = c; e.set = s; e.osc = o; e.len = n;
        q.push_back(e);
    endfunction

    // Step lists written from R2..R5; cycle waits of N give an N-cycle gap
    function automatic void build(bit frz, int ch);
        q.delete();
        if (ch < 3 && frz) begin
            push(9'h01C, 9'h000, 0, GWC - 1);
            push(9'h003, 9'h000, 0, 0);
        end else if (ch < 3) begin
            push(9'h000, 9'h003, 0, GWC - 1);
            push(9'h000, 9'h00C, 0, GWC - 1);
            push(9'h000, 9'h010, 0, 0);
        end else if (frz) begin
            push(9'h01C, 9'h000, 0, MWC - 1);
            push(9'h003, 9'h0C0, 0, MWC - 1);
            push(9'h100, 9'h020, 0, 0);
        end else begin
            push(9'h020, 9'h000, 0, MWC - 1);
            push(9'h000, 9'h100, 1, OL);
            push(9'h040, 9'h003, 1, OS);
            push(9'h000, 9'h00C, 0, MWC - 1);
            push(9'h080, 9'h000, 0, MWC - 1);
            push(9'h000, 9'h010, 0, 0);
        end
    endfunction

    always @(posedge clk) begin
        bit rise;
        mstep_t e;
        rise = osc_tick && !m_prev;
        if (!rst_n) begin
            for (int g = 0; g < 3; g++) m_gen[g] = 5'h00;
            m_mem = 9'h0E0; m_frozen = 4'hF;
            m_busy = 0; m_done = 0; m_err = 0; m_osc = 0;
            m_cnt = 0; m_stall = 0; m_prev = 0; m_op = 0; m_ch = 0;
            q.delete();
        end else begin
            m_done = 0; m_err = 0;
            if (!m_busy) begin
                if (req_valid) begin
                    if (req_chan > 3) m_err = 1;
                    else begin
                        m_busy = 1; m_op = req_freeze; m_ch = int'(req_chan);
                        build(req_freeze, int'(req_chan));
                        m_cnt = 0; m_osc = 0; m_stall = 0;
                    end
                end
            end else if (m_cnt == 0) begin
                e = q.pop_front();
                if (m_ch < 3) m_gen[m_ch] = (m_gen[m_ch] & ~e.clr[4:0]) | e.set[4:0];
                else m_mem = (m_mem & ~e.clr) | e.set;
                if (q.size() == 0) begin
                    m_busy = 0; m_done = 1; m_frozen[m_ch] = m_op;
                end else begin
                    m_cnt = e.len; m_osc = e.osc; m_stall = 0;
                end
            end else if (m_osc && m_stall >= SL) begin
                m_busy = 0; m_err = 1;
            end else if (!m_osc) begin
                m_cnt--;
            end else if (rise) begin
                m_cnt--; m_stall = 0;
            end else begin
                m_stall++;
            end
            m_prev = osc_tick;
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // compare away from the active edge, then drive the oscillator strobe
    always @(negedge clk) begin
        cycles++;
        if (started) begin
            logic [14:0] eg;
            bit bad;
            eg = {m_gen[2], m_gen[1], m_gen[0]};
            bad = 0;
            vectors++;
            if (gen_ctrl !== eg) begin
                $display("FAIL %s gen_ctrl actual %h expected %h", tag, gen_ctrl, eg); bad = 1;
            end
            if (mem_ctrl !== m_mem) begin
                $display("FAIL %s mem_ctrl actual %h expected %h", tag, mem_ctrl, m_mem); bad = 1;
            end
            if (frozen !== m_frozen) begin
                $display("FAIL %s frozen actual %h expected %h", tag, frozen, m_frozen); bad = 1;
            end
            if ({busy, done, err} !== {m_busy, m_done, m_err}) begin
                $display("FAIL %s busy/done/err actual %b expected %b", tag,
                         {busy, done, err}, {m_busy, m_done, m_err});
                bad = 1;
            end
            if (bad) miscompares++;
        end
        osc_tick <= osc_en && (osc_div % 4 == 0);
        osc_div++;
        if (cycles > 200000) begin
            $display("FAIL watchdog actual %0d cycles expected under 200000", cycles);
            miscompares++;
            finish_run();
        end
    end

    task automatic issue(input bit frz, input int ch);
        @(negedge clk);
        req_valid = 1; req_freeze = frz; req_chan = 3'(ch);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic settle();
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        started = 1;
        tag = "R1";
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        osc_en = 1;

        tag = "R3 R8 R10 R11"; issue(0, 0); settle();
        tag = "R2 R8 R10 R11"; issue(1, 0); settle();
        tag = "R3 R11";        issue(0, 1); settle();
        tag = "R3 R11";        issue(0, 2); settle();
        tag = "R2 R10";        issue(1, 2); settle();

        // memory thaw; a freeze request for channel 1 arrives mid-wait
        tag = "R5 R8 R10";
        issue(0, 3);
        repeat (200) @(negedge clk);
        tag = "R7";
        issue(1, 1);
        issue(0, 3);
        tag = "R5";
        settle();

        tag = "R4 R8 R10"; issue(1, 3); settle();

        tag = "R6"; issue(1, 5); repeat (2) @(negedge clk);
        issue(0, 7); repeat (2) @(negedge clk);
        issue(1, 4); settle();

        // stall: strobe stopped during a thaw of the memory bank
        osc_en = 0;
        repeat (4) @(negedge clk);
        tag = "R9"; issue(0, 3); settle();
        repeat (20) @(negedge clk);
        osc_en = 1;
        tag = "R4 R9"; issue(1, 3); settle();

        tag = "R2 R11"; issue(1, 1); settle();
        finish_run();
    end

endmodule